// File: doc/BRIEF.md
# Nine-Bit Serial Display Link Transmitter

This block drives a display controller whose serial port has no separate register-select pin. Every byte is sent as a nine-bit unit: a selector bit that says whether the byte is a command or a data value, followed by the byte itself. Bytes arrive on a valid/ready stream. Each byte carries a data/command tag, and a final-byte flag closes the current transaction.

While a transaction is open, chip select stays asserted. Units go out back to back on the serial line, with no stray bits between them. When the final byte has been shifted, the block checks how many bits have been sent. Because nine-bit units only line up with octets after a multiple of eight units, it appends filler command units until the bit total is a whole number of octets. Only then does it release chip select.

The serial clock follows the rising-edge-sampling, idle-low convention. Its half period is derived from parameters, so that the clock never runs faster than the panel's limit.

Top module: `ninebit_lcd_serializer`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0 and `in_ready` is 1.
- R2: Every byte is sent as a 9-bit unit whose first bit is the selector: 0 for a command byte (`in_is_data`=0), 1 for a data byte (`in_is_data`=1).
- R3: The 8 payload bits follow the selector bit, most significant bit first.
- R4: Within one transaction, units follow each other with no extra bits, and `cs_n` stays 0 from the first accepted byte until the transaction ends, even if the next byte arrives late.
- R5: After the byte flagged with `in_last`, the block appends filler units, each a selector bit of 0 followed by the byte `FILL_OP` MSB first. It keeps adding them until the transaction's unit count is a multiple of 8. A transaction of exactly 8 or 16 units gets no filler.
- R6: `sclk` is 0 whenever `cs_n` is 1, and `mosi` holds its value for the whole high phase of `sclk`.
- R7: Each high and low phase of `sclk` inside a unit lasts HALF system clocks, with HALF = ceil(CLK_HZ / (2·SCLK_MAX_HZ)). With the defaults this gives 5 clocks, so one serial period is 100 ns.
- R8: `in_ready` is 0 while a unit is shifting, and a byte is taken only in a cycle with `in_valid` and `in_ready` both 1.
- R9: `cs_n` returns to 1 right after the last unit of a transaction, filler included. The next transaction counts its units from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Payload byte |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_last | input | 1 | Byte closes the transaction |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |

## Verification
The bench sends transactions of 1, 3, 8, 9 and 16 units. These lengths separate the case that needs the most filler (seven units), a case that needs no filler, and the case where the count wraps past a multiple of eight. It also sends payloads of 00, FF, A5 and 5A with mixed command and data tags, so that a swapped selector polarity or a reversed bit order shows up in the serial stream. One transaction leaves idle gaps between its bytes, which checks that chip select is held and that the unit count survives the pause. Two transactions are sent back to back, which checks that the count restarts.

// File: rtl/ninebit_lcd_serializer.sv
module ninebit_lcd_serializer #(
  parameter int          CLK_HZ      = 100_000_000,
  parameter int          SCLK_MAX_HZ = 10_000_000,
  parameter logic [7:0]  FILL_OP     = 8'h5C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_is_data,
  input  logic       in_last,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n
);
  localparam int HALF = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

  typedef enum logic [1:0] {IDLE, SHIFT, HOLD} st_t;

  st_t           st;
  logic [8:0]    sh;
  logic [3:0]    bitn;
  logic [DW-1:0] div;
  logic          sclk_r;
  logic [2:0]    mod8;
  logic          last_r;

  wire       take   = in_valid && in_ready;
  wire       tick   = div == DW'(HALF - 1);
  wire [2:0] mod_nx = mod8 + 3'd1;

  assign in_ready = st != SHIFT;
  assign cs_n     = st == IDLE;
  assign sclk     = sclk_r;
  assign mosi     = (st == SHIFT) && sh[8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      sh     <= '0;
      bitn   <= '0;
      div    <= '0;
      sclk_r <= 1'b0;
      mod8   <= '0;
      last_r <= 1'b0;
    end else begin
      case (st)
        IDLE, HOLD: begin
          if (take) begin
            sh     <= {in_is_data, in_byte};
            bitn   <= '0;
            div    <= '0;
            sclk_r <= 1'b0;
            last_r <= in_last;
            st     <= SHIFT;
            if (st == IDLE) mod8 <= '0;
          end
        end
        SHIFT: begin
          if (!tick) begin
            div <= div + 1'b1;
          end else begin
            div <= '0;
            if (!sclk_r) begin
              sclk_r <= 1'b1;
            end else begin
              sclk_r <= 1'b0;
              if (bitn != 4'd8) begin
                sh   <= {sh[7:0], 1'b0};
                bitn <= bitn + 4'd1;
              end else begin
                mod8 <= mod_nx;
                if (!last_r) begin
                  st <= HOLD;
                end else if (mod_nx != 3'd0) begin
                  sh   <= {1'b0, FILL_OP};
                  bitn <= '0;
                end else begin
                  st <= IDLE;
                end
              end
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !in_ready);

  // R5
  pad_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (mod8 == 3'd0));

  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(last_r));

  // R4
  hold_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD) |-> !cs_n);
endmodule

// File: tb/sim_ninebit_lcd_serializer.sv
module sim_ninebit_lcd_serializer;
  localparam int          CLK_HZ = 100_000_000;
  localparam int          SMAX   = 10_000_000;
  localparam logic [7:0]  FILL   = 8'h5C;
  localparam int          HALF   = (CLK_HZ + 2 * SMAX - 1) / (2 * SMAX);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_data = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, sclk, mosi, cs_n;

  always #5 clk = ~clk;

  ninebit_lcd_serializer #(.CLK_HZ(CLK_HZ), .SCLK_MAX_HZ(SMAX), .FILL_OP(FILL)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .in_last(in_last),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

  int checks = 0, fails = 0;
  bit   exp_q[$];
  string tag_q[$];
  int   ntx = 0;
  bit   last_sent = 0;
  bit   done = 0;
  int   ends = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void push_unit(input bit flag, input logic [7:0] b, input bit filler);
    exp_q.push_back(flag);
    tag_q.push_back(filler ? "R5" : "R2");
    for (int i = 7; i >= 0; i--) begin
      exp_q.push_back(b[i]);
      tag_q.push_back(filler ? "R5" : "R3");
    end
  endfunction

  task automatic send(input bit d, input logic [7:0] b, input bit last, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1; in_is_data = d; in_byte = b; in_last = last;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    push_unit(d, b, 1'b0);
    ntx++;
    if (last) begin
      while (ntx % 8 != 0) begin
        push_unit(1'b0, FILL, 1'b1);
        ntx++;
      end
      last_sent = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    // R8: a shifting unit blocks further intake
    chk(!in_ready, "R8", "in_ready after accept", in_ready, 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "bits left after release", exp_q.size(), 0);
  endtask

  bit prev_sclk = 0, prev_mosi = 0, prev_cs = 1;
  int hicnt = 0, locnt = 0;
  bit low_busy = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      // R6
      chk(!(cs_n && sclk), "R6", "sclk high with cs_n high", sclk, 0);
      if (sclk && prev_sclk) begin
        // R6 / R8
        chk(mosi == prev_mosi, "R6", "mosi moved during high phase", mosi, prev_mosi);
        chk(!in_ready, "R8", "ready during high phase", in_ready, 0);
      end
      if (sclk && !prev_sclk) begin
        if (low_busy)
          chk(locnt == HALF, "R7", "low phase length", locnt, HALF);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected serial bit", mosi, -1);
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(mosi == e, t, "serial bit", mosi, e);
        end
        hicnt = 0;
      end
      if (!sclk && prev_sclk) begin
        chk(hicnt == HALF, "R7", "high phase length", hicnt, HALF);
        locnt = 0;
        low_busy = 1'b1;
      end
      if (sclk) hicnt++;
      else begin
        locnt++;
        if (in_ready) low_busy = 1'b0;
      end
      if (cs_n && !prev_cs) begin
        // R4 / R9
        chk(last_sent, "R4", "cs_n released before last byte", last_sent, 1);
        chk(exp_q.size() == 0, "R9", "cs_n released with bits pending", exp_q.size(), 0);
        last_sent = 1'b0;
        ntx = 0;
        ends++;
      end
      if (!cs_n && !last_sent && ntx == 0 && prev_cs)
        ;
      prev_sclk = sclk; prev_mosi = mosi; prev_cs = cs_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
    chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "idle lines after reset", {cs_n, sclk}, 2);

    // single command: seven filler units (R5)
    send(1'b0, 8'hA5, 1'b1, 0);
    wait_idle();

    // command plus fifteen data bytes: sixteen units, no filler (R5)
    send(1'b0, 8'h15, 1'b0, 0);
    for (int i = 0; i < 14; i++) send(1'b1, 8'(i * 37 + 3), 1'b0, 0);
    send(1'b1, 8'hFF, 1'b1, 0);
    wait_idle();

    // eight units with patterns 00/FF/A5/5A, mixed tags
    for (int i = 0; i < 8; i++)
      send(i[0], (i % 4 == 0) ? 8'h00 : (i % 4 == 1) ? 8'hFF : (i % 4 == 2) ? 8'hA5 : 8'h5A,
           i == 7, 0);
    wait_idle();

    // three units with idle gaps between them (R4)
    send(1'b0, 8'h5A, 1'b0, 0);
    send(1'b1, 8'h81, 1'b0, 25);
    chk(!cs_n, "R4", "cs_n during gap", cs_n, 0);
    send(1'b1, 8'h7E, 1'b1, 40);
    wait_idle();

    // nine units: count wraps, seven fillers, then a fresh transaction (R9)
    for (int i = 0; i < 9; i++) send(i != 0, 8'(8'hC3 ^ i), i == 8, 0);
    send(1'b0, 8'h01, 1'b1, 0);
    wait_idle();

    chk(ends == 6, "R9", "transactions closed", ends, 6);
    chk(cs_n && !sclk && in_ready, "R9", "idle at end", {cs_n, sclk, in_ready}, 5);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule